// File: doc/BRIEF.md
# Chainable FIFO Depth-Extension Stage

This block is one stage of a single-clock queue that can be built deeper by placing identical stages in a row. A parameter gives each stage a role. A solo stage is an ordinary standalone FIFO. A head stage takes words from the producer. A mid stage sits between two neighbours. A tail stage hands words to the consumer. Each stage keeps its own small store, and its oldest word is always visible at its outputs.

A mid or tail stage drains the stage in front of it without outside help. In any cycle where the upstream neighbour reports it is not empty and the local store has room, the stage raises its request toward upstream. On that same clock edge it captures the upstream head word, and the upstream stage retires that word. Words therefore move one hop per clock. Only the producer-facing stage shows a real full flag, and only the consumer-facing stage shows a real empty flag. The other stages hold those flags at a value that blocks access.

Top module: `cascade_fifo_stage`

## Requirements
- R1: After reset every stage is empty. A solo or head stage shows `full` = 0, and a solo or tail stage shows `empty` = 1.
- R2: A word accepted on a clock edge is visible on the read outputs after that edge, with `empty` = 0. This is show-ahead behaviour, so no read is needed to see the oldest word.
- R3: A stage holds at most DEPTH words. It raises full when DEPTH words are stored, and a write attempted while full is dropped without changing the stored contents.
- R4: A read attempted while empty is dropped. Words written afterwards are read back normally, with nothing extra and nothing missing.
- R5: When a write and a read are both accepted on the same edge, the occupancy stays the same and the order of words is kept.
- R6: A mid or tail stage raises `up_rd` exactly when `up_empty` = 0 and the stage is not full, and it stores `{up_data, up_par}` on that edge. A solo or head stage holds `up_rd` at 0.
- R7: In a chain of three stages (head, mid, tail) with any mix of producer and consumer stalls, every accepted word is read at the tail exactly once and in write order.
- R8: In an empty three-stage chain, a word written on edge k reaches the tail outputs after edge k+2. `empty` at the tail reads 1 after edges k and k+1.
- R9: A three-stage chain with a stalled consumer accepts exactly 3×DEPTH words before the head raises full.
- R10: A mid or tail stage drives `full` = 1 and ignores `push_valid`. A head or mid stage drives `empty` = 1 and ignores `pop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all stages of a chain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_valid | input | 1 | Producer write request (solo or head role) |
| push_data | input | DATA_W | Producer data word |
| push_par | input | PAR_W | Producer side bits stored with the word |
| full | output | 1 | Store full (solo or head role); held 1 in the other roles |
| pop | input | 1 | Consumer read request (solo or tail role) |
| pop_data | output | DATA_W | Oldest stored data word |
| pop_par | output | PAR_W | Side bits of the oldest stored word |
| empty | output | 1 | Store empty (solo or tail role); held 1 in the other roles |
| up_data | input | DATA_W | Head word offered by the upstream stage |
| up_par | input | PAR_W | Side bits offered by the upstream stage |
| up_empty | input | 1 | Upstream stage has nothing to offer |
| up_rd | output | 1 | Takes one word from upstream on this edge |
| dn_data | output | DATA_W | Head word offered to the downstream stage |
| dn_par | output | PAR_W | Side bits offered to the downstream stage |
| dn_empty | output | 1 | This stage has nothing to offer downstream |
| dn_rd | input | 1 | Downstream stage takes the offered word on this edge |

## Verification
Inside a stage, every result is due one edge after its stimulus. A word written on an edge, a pop, or a dropped write or read shows on the flags and read outputs right after that edge. The request toward upstream is combinational on the neighbour's empty flag and the local full flag, so it is valid in the same cycle. Across the chain, each hop adds one edge, so the tail sees a word two edges after the head accepts it. The bench drives inputs at the falling edge and samples outputs at the next falling edge, which is half a period after the edge that causes the change. Latency checks count edges one by one. Order checks drain through a scoreboard queue, with a cycle limit in place of a fixed delay.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

  typedef enum logic [1:0] {
    ROLE_SOLO = 2'd0,
    ROLE_HEAD = 2'd1,
    ROLE_MID  = 2'd2,
    ROLE_TAIL = 2'd3
  } role_e;

  function automatic bit role_pulls_upstream(role_e r);
    return (r == ROLE_MID) || (r == ROLE_TAIL);
  endfunction

  function automatic bit role_meets_producer(role_e r);
    return (r == ROLE_SOLO) || (r == ROLE_HEAD);
  endfunction

  function automatic bit role_meets_consumer(role_e r);
    return (r == ROLE_SOLO) || (r == ROLE_TAIL);
  endfunction

endpackage

// File: rtl/cfs_rst_sync.sv
module cfs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end
endmodule

// File: rtl/cfs_ctrl.sv
module cfs_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] OCC_MAX  = CW'(DEPTH);

  logic [AW-1:0] wr_ptr_d, rd_ptr_d;
  logic [CW-1:0] occ_d;

  assign full    = (occ == OCC_MAX);
  assign empty   = (occ == '0);
  assign wr_fire = wr_req && !full;
  assign rd_fire = rd_req && !empty;

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    occ_d    = occ;
    if (wr_fire) wr_ptr_d = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
    if (rd_fire) rd_ptr_d = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
    case ({wr_fire, rd_fire})
      2'b10:   occ_d = occ + 1'b1;
      2'b01:   occ_d = occ - 1'b1;
      default: occ_d = occ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr_d;
      if (rd_fire) rd_ptr <= rd_ptr_d;
      if (wr_fire != rd_fire) occ <= occ_d;
    end
  end
endmodule

// File: rtl/cfs_store.sv
module cfs_store #(
  parameter int WIDTH = 72,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // show-ahead: oldest word is read without a clock
  assign rdata = mem[raddr];
endmodule

// File: rtl/cascade_fifo_stage.sv
module cascade_fifo_stage
  import cfs_pkg::*;
#(
  parameter role_e ROLE   = ROLE_SOLO,
  parameter int    DATA_W = 64,
  parameter int    PAR_W  = 8,
  parameter int    DEPTH  = 16,
  localparam int   WW = DATA_W + PAR_W,
  localparam int   AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int   CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic [PAR_W-1:0]  push_par,
  output logic              full,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [PAR_W-1:0]  pop_par,
  output logic              empty,
  input  logic [DATA_W-1:0] up_data,
  input  logic [PAR_W-1:0]  up_par,
  input  logic              up_empty,
  output logic              up_rd,
  output logic [DATA_W-1:0] dn_data,
  output logic [PAR_W-1:0]  dn_par,
  output logic              dn_empty,
  input  logic              dn_rd
);
  logic          srst_n;
  logic          wr_req, rd_req, wr_fire, rd_fire;
  logic          loc_full, loc_empty;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ;
  logic [WW-1:0] wr_word, hd_word;

  cfs_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cfs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_req  (wr_req),
    .rd_req  (rd_req),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .occ     (occ),
    .full    (loc_full),
    .empty   (loc_empty)
  );

  cfs_store #(.WIDTH(WW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wr_ptr),
    .wdata (wr_word),
    .raddr (rd_ptr),
    .rdata (hd_word)
  );

  // write side: producer or upstream neighbour
  if (role_pulls_upstream(ROLE)) begin : g_wr_cascade
    assign wr_req  = !up_empty;
    assign wr_word = {up_data, up_par};
    assign up_rd   = wr_fire;
    assign full    = 1'b1;
    wire unused_push = ^{push_valid, push_data, push_par};
  end else begin : g_wr_producer
    assign wr_req  = push_valid;
    assign wr_word = {push_data, push_par};
    assign up_rd   = 1'b0;
    assign full    = loc_full;
    wire unused_up = ^{up_data, up_par, up_empty};
  end

  // read side: consumer or downstream neighbour
  if (role_meets_consumer(ROLE)) begin : g_rd_consumer
    assign rd_req = pop;
    assign empty  = loc_empty;
    wire unused_dn = dn_rd;
  end else begin : g_rd_cascade
    assign rd_req = dn_rd;
    assign empty  = 1'b1;
    wire unused_pop = pop;
  end

  assign pop_data = hd_word[WW-1:PAR_W];
  assign pop_par  = hd_word[PAR_W-1:0];
  assign dn_data  = hd_word[WW-1:PAR_W];
  assign dn_par   = hd_word[PAR_W-1:0];
  assign dn_empty = loc_empty;
endmodule

// File: rtl/cfs_stage_chk.sv
module cfs_stage_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_req,
  input logic          rd_req,
  input logic          wr_fire,
  input logic          rd_fire,
  input logic          loc_full,
  input logic          loc_empty,
  input logic          up_rd,
  input logic [CW-1:0] occ
);
  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  // R3
  hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_full && !rd_req) |=> (loc_full && $stable(occ)));

  // R4
  hold_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_empty && !wr_req) |=> loc_empty);

  // R2
  show_ahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_empty && wr_fire) |=> !loc_empty);

  // R5
  both_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_fire) |=> $stable(occ));

  // R6
  pull_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rd && !rd_fire) |=> (occ == CW'($past(occ) + 1'b1)));
endmodule

bind cascade_fifo_stage cfs_stage_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .wr_req    (wr_req),
  .rd_req    (rd_req),
  .wr_fire   (wr_fire),
  .rd_fire   (rd_fire),
  .loc_full  (loc_full),
  .loc_empty (loc_empty),
  .up_rd     (up_rd),
  .occ       (occ)
);

// File: tb/cascade_fifo_stage_test.sv
`timescale 1ns/1ps
module cascade_fifo_stage_test;
  import cfs_pkg::*;

  localparam int DW = 64;
  localparam int PW = 8;
  localparam int DEPTH = 16;
  localparam int WW = DW + PW;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // solo stage
  logic          s_push, s_pop, s_full, s_empty, s_uprd, s_dnempty;
  logic [DW-1:0] s_pdata, s_odata, s_dndata;
  logic [PW-1:0] s_ppar, s_opar, s_dnpar;

  cascade_fifo_stage #(.ROLE(ROLE_SOLO), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(s_push), .push_data(s_pdata), .push_par(s_ppar), .full(s_full),
    .pop(s_pop), .pop_data(s_odata), .pop_par(s_opar), .empty(s_empty),
    .up_data('0), .up_par('0), .up_empty(1'b1), .up_rd(s_uprd),
    .dn_data(s_dndata), .dn_par(s_dnpar), .dn_empty(s_dnempty), .dn_rd(1'b0)
  );

  // three-stage chain
  logic          c_push, c_pop;
  logic [DW-1:0] c_pdata;
  logic [PW-1:0] c_ppar;
  logic          h_full, h_empty, h_uprd, h_dnempty;
  logic [DW-1:0] h_odata, h_dndata;
  logic [PW-1:0] h_opar, h_dnpar;
  logic          m_full, m_empty, m_uprd, m_dnempty;
  logic [DW-1:0] m_odata, m_dndata;
  logic [PW-1:0] m_opar, m_dnpar;
  logic          t_full, t_empty, t_uprd, t_dnempty;
  logic [DW-1:0] t_odata, t_dndata;
  logic [PW-1:0] t_opar, t_dnpar;

  // head: pop tied high, must be ignored (R10)
  cascade_fifo_stage #(.ROLE(ROLE_HEAD), .DEPTH(DEPTH)) chain_head (
    .clk(clk), .rst_n(rst_n),
    .push_valid(c_push), .push_data(c_pdata), .push_par(c_ppar), .full(h_full),
    .pop(1'b1), .pop_data(h_odata), .pop_par(h_opar), .empty(h_empty),
    .up_data('0), .up_par('0), .up_empty(1'b1), .up_rd(h_uprd),
    .dn_data(h_dndata), .dn_par(h_dnpar), .dn_empty(h_dnempty), .dn_rd(m_uprd)
  );

  // mid: push and pop both tied high, must be ignored (R10)
  cascade_fifo_stage #(.ROLE(ROLE_MID), .DEPTH(DEPTH)) chain_mid (
    .clk(clk), .rst_n(rst_n),
    .push_valid(1'b1), .push_data({DW{1'b1}}), .push_par({PW{1'b1}}), .full(m_full),
    .pop(1'b1), .pop_data(m_odata), .pop_par(m_opar), .empty(m_empty),
    .up_data(h_dndata), .up_par(h_dnpar), .up_empty(h_dnempty), .up_rd(m_uprd),
    .dn_data(m_dndata), .dn_par(m_dnpar), .dn_empty(m_dnempty), .dn_rd(t_uprd)
  );

  // tail: push tied high with junk, dn_rd tied high, both ignored (R10)
  cascade_fifo_stage #(.ROLE(ROLE_TAIL), .DEPTH(DEPTH)) chain_tail (
    .clk(clk), .rst_n(rst_n),
    .push_valid(1'b1), .push_data({DW{1'b1}}), .push_par(8'hA5), .full(t_full),
    .pop(c_pop), .pop_data(t_odata), .pop_par(t_opar), .empty(t_empty),
    .up_data(m_dndata), .up_par(m_dnpar), .up_empty(m_dnempty), .up_rd(t_uprd),
    .dn_data(t_dndata), .dn_par(t_dnpar), .dn_empty(t_dnempty), .dn_rd(1'b1)
  );

  logic [WW-1:0] exp_q[$];

  function automatic logic [WW-1:0] mk_word(int n);
    logic [31:0] a;
    a = 32'(n) * 32'h9E37_79B1;
    return {a, a ^ 32'hC3A5_0F1E, 8'(n * 7 + 3)};
  endfunction

  task automatic check(string req, logic [WW-1:0] act, logic [WW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    s_push = 0; s_pop = 0; s_pdata = '0; s_ppar = '0;
    c_push = 0; c_pop = 0; c_pdata = '0; c_ppar = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    check("R1 solo empty", s_empty, 1);
    check("R1 solo full", s_full, 0);
    check("R1 head full", h_full, 0);
    check("R1 tail empty", t_empty, 1);
    check("R10 head empty held", h_empty, 1);
    check("R10 mid full held", m_full, 1);
    check("R10 tail full held", t_full, 1);
    check("R6 head up_rd", h_uprd, 0);
  endtask

  task automatic s_write(logic [WW-1:0] w);
    s_push = 1; {s_pdata, s_ppar} = w;
    step();
    s_push = 0;
  endtask

  task automatic t_solo_basic();
    logic [WW-1:0] w = mk_word(1);
    s_write(w);
    check("R2 empty after write", s_empty, 0);
    check("R2 show-ahead data", {s_odata, s_opar}, w);
    s_pop = 1; step(); s_pop = 0;
    check("R2 empty after pop", s_empty, 1);
  endtask

  task automatic t_solo_underflow();
    s_pop = 1; repeat (3) step(); s_pop = 0;
    check("R4 still empty", s_empty, 1);
    s_write(mk_word(20));
    s_write(mk_word(21));
    check("R4 first after underflow", {s_odata, s_opar}, mk_word(20));
    s_pop = 1; step();
    check("R4 second after underflow", {s_odata, s_opar}, mk_word(21));
    step(); s_pop = 0;
    check("R4 drained exactly", s_empty, 1);
  endtask

  task automatic t_solo_full();
    for (int i = 0; i < DEPTH; i++) begin
      check("R3 not full early", s_full, 0);
      s_write(mk_word(100 + i));
    end
    check("R3 full at DEPTH", s_full, 1);
    s_push = 1; {s_pdata, s_ppar} = mk_word(999);
    repeat (2) step();
    s_push = 0;
    check("R3 full kept", s_full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      check("R3 order after full", {s_odata, s_opar}, mk_word(100 + i));
      s_pop = 1; step(); s_pop = 0;
    end
    check("R3 dropped write absent", s_empty, 1);
  endtask

  task automatic t_solo_simul();
    s_write(mk_word(40));
    s_write(mk_word(41));
    check("R5 head before", {s_odata, s_opar}, mk_word(40));
    s_push = 1; {s_pdata, s_ppar} = mk_word(42); s_pop = 1;
    step();
    s_push = 0;
    check("R5 head after both", {s_odata, s_opar}, mk_word(41));
    check("R5 not empty", s_empty, 0);
    step();
    check("R5 third word", {s_odata, s_opar}, mk_word(42));
    step(); s_pop = 0;
    check("R5 occupancy kept", s_empty, 1);
  endtask

  task automatic drain_chain(string req);
    int guard = 0;
    while (exp_q.size() > 0 && guard < 2000) begin
      if (!t_empty) begin
        check(req, {t_odata, t_opar}, exp_q.pop_front());
        c_pop = 1;
      end else begin
        c_pop = 0;
      end
      step();
      guard++;
    end
    c_pop = 0;
    repeat (3) step();
    check({req, " no extra words"}, t_empty, 1);
    check({req, " queue emptied"}, 72'(exp_q.size()), 0);
  endtask

  task automatic t_chain_latency();
    logic [WW-1:0] w = mk_word(7);
    c_push = 1; {c_pdata, c_ppar} = w;
    step();
    c_push = 0;
    check("R8 tail empty after k", t_empty, 1);
    check("R6 mid pulls", m_uprd, 1);
    check("R6 head never pulls", h_uprd, 0);
    step();
    check("R8 tail empty after k+1", t_empty, 1);
    check("R6 tail pulls", t_uprd, 1);
    step();
    check("R8 tail ready after k+2", t_empty, 0);
    check("R8 tail data", {t_odata, t_opar}, w);
    c_pop = 1; step(); c_pop = 0;
    check("R8 tail empty after pop", t_empty, 1);
  endtask

  task automatic t_chain_capacity();
    int acc = 0;
    for (int i = 0; i < 4 * DEPTH + 20; i++) begin
      if (!h_full) begin
        c_push = 1; {c_pdata, c_ppar} = mk_word(500 + acc);
        exp_q.push_back(mk_word(500 + acc));
        acc++;
      end else begin
        c_push = 0;
      end
      step();
    end
    c_push = 0;
    check("R9 accepted words", 72'(acc), 72'(3 * DEPTH));
    check("R9 head full", h_full, 1);
    check("R6 mid stops when full", m_uprd, 0);
    check("R10 tail full held", t_full, 1);
    check("R10 mid empty held", m_empty, 1);
    drain_chain("R9 order");
    check("R9 head full cleared", h_full, 0);
  endtask

  task automatic t_chain_stream();
    int n = 0;
    for (int i = 0; i < 600; i++) begin
      if (!t_empty && (i % 5 != 2) && (i % 11 != 0)) begin
        check("R7 stream order", {t_odata, t_opar}, exp_q.pop_front());
        c_pop = 1;
      end else begin
        c_pop = 0;
      end
      if (!h_full && (i % 3 != 1) && (i < 500)) begin
        c_push = 1; {c_pdata, c_ppar} = mk_word(2000 + n);
        exp_q.push_back(mk_word(2000 + n));
        n++;
      end else begin
        c_push = 0;
      end
      step();
    end
    c_push = 0; c_pop = 0;
    drain_chain("R7 stream tail");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_solo_basic();
    t_solo_underflow();
    t_solo_full();
    t_solo_simul();
    t_chain_latency();
    t_chain_capacity();
    t_chain_stream();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule